// File: doc/BRIEF.md
# Edge-Timestamp Capture Queue

This block watches four digital input lines and records when selected transitions happen on them. Each line has its own trigger mode. When a line's trigger fires, the block samples a free-running timer that comes in from outside. It writes that timer value into a queue of pending events. With each timestamp it stores a cause mask with one bit per line. If triggers on several lines fire in the same clock, they share a single queue entry, and the mask shows every line that fired.

The oldest pending entry is always kept in a holding stage at the block's outputs. Software unloads it in two steps. It first reads the status (availability flag, overflow flag and cause mask), then reads the time. The time read is what retires the entry and brings the next one forward. A time read that was not preceded by a status read leaves the queue unchanged. This prevents a stray time access from discarding an event whose cause was never inspected. The line inputs are synchronised internally, so they may be fully asynchronous to the clock.

Top module: `edge_stamp_queue`

## Requirements
- R1: A line in mode 2'b00 creates an event on each 0-to-1 transition and none on 1-to-0.
- R2: A line in mode 2'b01 creates an event on each 1-to-0 transition and none on 0-to-1.
- R3: A line in mode 2'b10 creates an event on every transition in either direction.
- R4: A line in mode 2'b11 creates an event on every eighth 0-to-1 transition. Its rise counter restarts from zero whenever the mode register is written, even with the same value.
- R5: Each entry holds the timer value present in the capture cycle and a mask whose bit i is 1 when line i fired. Lines that fire in the same cycle produce one entry with several mask bits set.
- R6: Entries leave in arrival order. At most 8 entries are held in total, and the holding stage counts as one of them.
- R7: Asserting the time read pops the holding entry only when a status read has occurred since the last pop. Otherwise the status and time outputs are unchanged.
- R8: An event that arrives while 8 entries are held is discarded and sets the overflow flag. The flag stays set until a status read clears it.
- R9: A time read while nothing is held leaves the time output at its last value and the availability flag low.
- R10: After reset the availability and overflow flags are 0, the time output is 0, and all lines are in mode 2'b00. Line i's mode lives in bits [2i+1:2i] of the mode register, which is loaded from `mode_i` when `mode_we_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_i | input | 16 | Free-running timer value to be captured |
| lines_i | input | 4 | Monitored event lines, asynchronous |
| mode_we_i | input | 1 | Load the mode register from mode_i |
| mode_i | input | 8 | Per-line trigger modes, 2 bits per line |
| rd_stat_i | input | 1 | Status read strobe |
| rd_time_i | input | 1 | Time read strobe |
| stat_mask_o | output | 4 | Cause mask of the holding entry |
| avail_o | output | 1 | Holding entry is valid |
| ovf_o | output | 1 | Sticky overflow flag |
| time_o | output | 16 | Timestamp of the holding entry |

## Verification
Each line is driven in its own mode with both rising and falling pulses. A mode that reacts to the wrong polarity therefore adds or loses an entry in the expected stream. Two lines are raised together to separate merged entries from split ones. The divide-by-eight line receives runs of seven, eight and sixteen rises, both with and without a mode write in between, to expose an off-by-one or a counter that is never cleared. Nine back-to-back events test the depth limit and the overflow flag. A time read issued without a status read, and another issued on an empty queue, show whether popping is correctly gated.

// File: rtl/edge_stamp_queue.sv
module edge_stamp_queue #(
  parameter int NL    = 4,
  parameter int TW    = 16,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   timer_i,
  input  logic [NL-1:0]   lines_i,
  input  logic            mode_we_i,
  input  logic [2*NL-1:0] mode_i,
  input  logic            rd_stat_i,
  input  logic            rd_time_i,
  output logic [NL-1:0]   stat_mask_o,
  output logic            avail_o,
  output logic            ovf_o,
  output logic [TW-1:0]   time_o
);
  localparam int FD = DEPTH - 1;
  localparam int PW = (FD > 1) ? $clog2(FD) : 1;
  localparam int CW = $clog2(FD + 1);
  localparam int EW = NL + TW;

  logic [NL-1:0]   s1, s2, s3;
  logic [2*NL-1:0] mode_q;
  logic [2:0]      div [NL];
  logic [NL-1:0]   ev;

  wire [NL-1:0] rise = s2 & ~s3;
  wire [NL-1:0] fall = ~s2 & s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; mode_q <= '0;
    end else begin
      s1 <= lines_i; s2 <= s1; s3 <= s2;
      if (mode_we_i) mode_q <= mode_i;
    end

  always_comb
    for (int i = 0; i < NL; i++)
      case (mode_q[2*i +: 2])
        2'b00:   ev[i] = rise[i];
        2'b01:   ev[i] = fall[i];
        2'b10:   ev[i] = rise[i] | fall[i];
        default: ev[i] = rise[i] && div[i] == 3'd7;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    for (int i = 0; i < NL; i++)
      if (!rst_n)                                 div[i] <= '0;
      else if (mode_we_i)                         div[i] <= '0;
      else if (rise[i] && mode_q[2*i +: 2] == 2'b11) div[i] <= div[i] + 3'd1;

  logic [EW-1:0] mem [FD];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fcnt;
  logic          hv, armed, ovf;
  logic [NL-1:0] hmask;
  logic [TW-1:0] htime;

  wire push    = |ev;
  wire pop     = rd_time_i & armed & hv;
  wire take    = ~hv | pop;
  wire from_f  = take && fcnt != '0;
  wire to_hold = take && fcnt == '0 && push;
  wire to_fifo = push && !to_hold && (fcnt != CW'(FD) || from_f);
  wire drop    = push && !to_hold && !to_fifo;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(FD - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk)
    if (to_fifo) mem[wp] <= {ev, timer_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0;
      hv <= 1'b0; armed <= 1'b0; ovf <= 1'b0;
      hmask <= '0; htime <= '0;
    end else begin
      if (to_fifo) wp <= nxt(wp);
      if (from_f)  rp <= nxt(rp);
      fcnt <= fcnt + CW'(to_fifo) - CW'(from_f);
      if (from_f) begin
        {hmask, htime} <= mem[rp];
        hv <= 1'b1;
      end else if (to_hold) begin
        {hmask, htime} <= {ev, timer_i};
        hv <= 1'b1;
      end else if (pop) hv <= 1'b0;
      if (pop)                  armed <= 1'b0;
      else if (rd_stat_i && hv) armed <= 1'b1;
      if (drop)           ovf <= 1'b1;
      else if (rd_stat_i) ovf <= 1'b0;
    end

  assign stat_mask_o = hmask;
  assign avail_o     = hv;
  assign ovf_o       = ovf;
  assign time_o      = htime;
endmodule

// File: rtl/edge_stamp_queue_chk.sv
module edge_stamp_queue_chk #(
  parameter int NL = 4,
  parameter int TW = 16,
  parameter int CW = 3,
  parameter int FD = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stat_i,
  input logic          rd_time_i,
  input logic          avail_o,
  input logic          ovf_o,
  input logic [NL-1:0] stat_mask_o,
  input logic [TW-1:0] time_o,
  input logic [NL-1:0] ev,
  input logic          armed,
  input logic [CW-1:0] fcnt
);
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !rd_stat_i |=> ovf_o); // R8
  AST_NO_POP_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_time_i && avail_o && !armed |=> avail_o && $stable(time_o) && $stable(stat_mask_o)); // R7
  AST_EMPTY_TIME_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_time_i && !avail_o && ev == '0 |=> $stable(time_o) && !avail_o); // R9
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    avail_o |-> stat_mask_o != '0); // R5
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CW'(FD) && (avail_o || fcnt == '0)); // R6
endmodule

bind edge_stamp_queue edge_stamp_queue_chk #(.NL(NL), .TW(TW), .CW(CW), .FD(FD)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_stat_i(rd_stat_i), .rd_time_i(rd_time_i),
  .avail_o(avail_o), .ovf_o(ovf_o), .stat_mask_o(stat_mask_o), .time_o(time_o),
  .ev(ev), .armed(armed), .fcnt(fcnt)
);

// File: tb/edge_stamp_queue_tb_top.sv
module edge_stamp_queue_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] timer_i = '0;
  logic [3:0]  lines_i = '0;
  logic        mode_we_i = 1'b0;
  logic [7:0]  mode_i = '0;
  logic        rd_stat_i = 1'b0, rd_time_i = 1'b0;
  logic [3:0]  stat_mask_o;
  logic        avail_o, ovf_o;
  logic [15:0] time_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [19:0] sb [$];

  always #2 clk = ~clk;

  edge_stamp_queue dut_i (
    .clk(clk), .rst_n(rst_n), .timer_i(timer_i), .lines_i(lines_i),
    .mode_we_i(mode_we_i), .mode_i(mode_i), .rd_stat_i(rd_stat_i), .rd_time_i(rd_time_i),
    .stat_mask_o(stat_mask_o), .avail_o(avail_o), .ovf_o(ovf_o), .time_o(time_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_lines(input logic [3:0] v, input logic [15:0] t);
    @(negedge clk);
    timer_i = t; lines_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input int line, input logic [15:0] t);
    set_lines(4'(1 << line), t);
    set_lines(4'b0000, t + 16'd1);
  endtask

  task automatic write_mode(input logic [7:0] v);
    @(negedge clk); mode_i = v; mode_we_i = 1'b1;
    @(negedge clk); mode_we_i = 1'b0;
  endtask

  task automatic expect_ev(input logic [3:0] m, input logic [15:0] t);
    sb.push_back({m, t});
  endtask

  task automatic drain(input string req);
    while (sb.size() != 0) begin
      logic [19:0] e;
      e = sb.pop_front();
      @(negedge clk);
      chk(avail_o == 1'b1, req, avail_o, 1);
      chk(stat_mask_o == e[19:16], req, stat_mask_o, e[19:16]);
      rd_stat_i = 1'b1;
      @(negedge clk);
      rd_stat_i = 1'b0;
      chk(time_o == e[15:0], req, time_o, e[15:0]);
      rd_time_i = 1'b1;
      @(negedge clk);
      rd_time_i = 1'b0;
    end
    @(negedge clk);
    chk(avail_o == 1'b0, req, avail_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(avail_o == 1'b0, "R10", avail_o, 0);
    chk(ovf_o == 1'b0, "R10", ovf_o, 0);
    chk(time_o == 16'h0, "R10", time_o, 0);
    pulse(2, 16'h0020);
    expect_ev(4'b0100, 16'h0020);
    drain("R10 default rise mode");

    write_mode(8'b11_10_01_00);
    set_lines(4'b0001, 16'd100); expect_ev(4'b0001, 16'd100);   // R1
    set_lines(4'b0000, 16'd110);                                 // R1 no fall
    set_lines(4'b0010, 16'd120);                                 // R2 no rise
    set_lines(4'b0000, 16'd130); expect_ev(4'b0010, 16'd130);   // R2
    set_lines(4'b0100, 16'd140); expect_ev(4'b0100, 16'd140);   // R3
    set_lines(4'b0000, 16'd150); expect_ev(4'b0100, 16'd150);   // R3

    // R7 time read without status read keeps the entry
    @(negedge clk); rd_time_i = 1'b1;
    @(negedge clk); rd_time_i = 1'b0;
    chk(avail_o == 1'b1, "R7", avail_o, 1);
    chk(time_o == 16'd100, "R7", time_o, 100);
    chk(stat_mask_o == 4'b0001, "R7", stat_mask_o, 1);
    drain("R1 R2 R3 R6");

    // R9 empty time read
    @(negedge clk); rd_stat_i = 1'b1;
    @(negedge clk); rd_stat_i = 1'b0; rd_time_i = 1'b1;
    @(negedge clk); rd_time_i = 1'b0;
    chk(time_o == 16'd150, "R9", time_o, 150);
    chk(avail_o == 1'b0, "R9", avail_o, 0);

    // R5 merge of simultaneous edges
    write_mode(8'h00);
    set_lines(4'b1001, 16'd200); expect_ev(4'b1001, 16'd200);
    set_lines(4'b0000, 16'd210);
    drain("R5");

    // R4 every eighth rise
    write_mode(8'b11_00_00_00);
    for (int i = 0; i < 7; i++) pulse(3, 16'(300 + 2 * i));
    @(negedge clk);
    chk(avail_o == 1'b0, "R4 seven rises", avail_o, 0);
    pulse(3, 16'd400); expect_ev(4'b1000, 16'd400);
    for (int i = 0; i < 7; i++) pulse(3, 16'(410 + 2 * i));
    pulse(3, 16'd450); expect_ev(4'b1000, 16'd450);
    drain("R4");
    for (int i = 0; i < 5; i++) pulse(3, 16'(460 + 2 * i));
    write_mode(8'b11_00_00_00);
    for (int i = 0; i < 7; i++) pulse(3, 16'(480 + 2 * i));
    @(negedge clk);
    chk(avail_o == 1'b0, "R4 counter restart", avail_o, 0);
    pulse(3, 16'd499); expect_ev(4'b1000, 16'd499);
    drain("R4 restart");

    // R6 R8 depth and overflow
    write_mode(8'h00);
    for (int i = 0; i < 9; i++) begin
      pulse(0, 16'(600 + 10 * i));
      if (i < 8) expect_ev(4'b0001, 16'(600 + 10 * i));
    end
    @(negedge clk);
    chk(ovf_o == 1'b1, "R8 set", ovf_o, 1);
    pulse(1, 16'd700);
    chk(ovf_o == 1'b1, "R8 sticky", ovf_o, 1);
    drain("R6 R8 order and drop");
    chk(ovf_o == 1'b0, "R8 cleared", ovf_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule